// File: doc/BRIEF.md
# Top-of-Memory Protected Segment Decoder

This block sits between a byte-wide memory requester and a backing RAM and hides a protected window at the very top of installed memory. The window starts at the installed RAM size minus a selected size, in megabyte units, and runs to the top of RAM. A 3-bit size code picks 1, 2 or 8 MB, or switches to a separately supplied extended megabyte count.

Protection is active only when both a global enable and a segment enable are set. A non-privileged access that falls in the window is blocked. A privileged access is also blocked when the close control is set. Blocked reads return all-ones, and blocked writes never reach the RAM port. Every other access is forwarded to the RAM port unchanged, in the same cycle.

The RAM port is expected to register read data on the clock edge after a forwarded read. The block registers its read response on that same edge.

Top module: `topmem_shield`

## Requirements
- R1: Size code 3'b000 selects 1 MB, 3'b001 selects 2 MB and 3'b010 selects 8 MB. The window covers the megabyte indices from RAM_MB minus the size up to RAM_MB minus one.
- R2: Size code 3'b111 takes the size from `extSizeMb`. A value of zero gives no window. A value of RAM_MB or more makes the window cover all of RAM.
- R3: Size codes 3'b011 to 3'b110 give no window, so every address passes through.
- R4: An access is blocked when all of these hold: `globalEnable` and `segmentEnable` are both 1, the address is in the window, and either `reqPriv` is 0 or `closeSeg` is 1. A blocked read answers with `rspRdata` = 8'hFF.
- R5: A blocked write leaves `ramValid` low, so the byte keeps its earlier contents.
- R6: With `globalEnable` or `segmentEnable` at 0, every access is forwarded whatever its address or privilege.
- R7: A privileged access with `closeSeg` at 0 is forwarded even inside the window.
- R8: The byte just below the window start stays readable and writable under every mode.
- R9: An allowed access drives `ramValid`, `ramAddr`, `ramWrite` and `ramWdata` in its own cycle. Every read, blocked or not, raises `rspValid` on the next clock edge. Writes raise no response.
- R10: While `rstN` is low, `rspValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| globalEnable | input | 1 | Master protection enable |
| segmentEnable | input | 1 | Top window enable |
| closeSeg | input | 1 | Blocks privileged accesses too |
| sizeCode | input | 3 | Window size selector |
| extSizeMb | input | EXT_W | Extended window size in MB |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqPriv | input | 1 | Request is privileged |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 8 | Write byte |
| rspValid | output | 1 | Read response strobe |
| rspRdata | output | 8 | Read response byte |
| ramValid | output | 1 | Forwarded request strobe |
| ramWrite | output | 1 | Forwarded write flag |
| ramAddr | output | ADDR_W | Forwarded address |
| ramWdata | output | 8 | Forwarded write byte |
| ramRdata | input | 8 | RAM read byte, one edge after a read |

## Verification
The RAM-port outputs are combinational from the request, so the bench samples them one time step after it drives a request, before the next clock edge. Read responses are due exactly one clock edge later. The bench drives each request on a falling edge and checks the response on the following falling edge, before it drives the next request. Write-suppression results show up only on later reads, so every sweep writes all bytes and then reads all bytes back. The reads are compared against a shadow copy that the bench updates only for writes it expects to be forwarded.

// File: rtl/topmem_shield_pkg.sv
package topmem_shield_pkg;

  typedef struct packed {
    logic fwd;        // request goes to RAM port this cycle
    logic dropWrite;  // write swallowed this cycle
    logic readDue;    // registered: read response this cycle
    logic maskDue;    // registered: response must be filled
  } ctrlStrobe_t;

  localparam logic [2:0] SZ_1MB = 3'b000;
  localparam logic [2:0] SZ_2MB = 3'b001;
  localparam logic [2:0] SZ_8MB = 3'b010;
  localparam logic [2:0] SZ_EXT = 3'b111;

  localparam logic [7:0] BLOCK_FILL = 8'hFF;

endpackage

// File: rtl/topmem_size_decode.sv
module topmem_size_decode
  import topmem_shield_pkg::*;
#(
  parameter int RAM_MB = 128,
  parameter int EXT_W  = 12,
  parameter int IDX_W  = $clog2(RAM_MB)
) (
  input  logic [2:0]       sizeCode,
  input  logic [EXT_W-1:0] extSizeMb,
  output logic             segActive,
  output logic [IDX_W-1:0] startMb
);

  localparam int SZ_A = (EXT_W > 4) ? EXT_W : 4;
  localparam int SZ_W = (SZ_A > IDX_W) ? SZ_A : IDX_W + 1;

  logic [SZ_W-1:0] sizeMb;
  logic            coversAll;

  always_comb begin
    case (sizeCode)
      SZ_1MB:  sizeMb = SZ_W'(1);
      SZ_2MB:  sizeMb = SZ_W'(2);
      SZ_8MB:  sizeMb = SZ_W'(8);
      SZ_EXT:  sizeMb = SZ_W'(extSizeMb);
      default: sizeMb = '0;
    endcase
  end

  assign coversAll = (sizeMb >= SZ_W'(RAM_MB));

  always_comb begin
    segActive = (sizeMb != '0);
    if (coversAll) startMb = '0;
    else           startMb = IDX_W'(RAM_MB) - sizeMb[IDX_W-1:0];
  end

endmodule

// File: rtl/topmem_ctrl.sv
module topmem_ctrl
  import topmem_shield_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        globalEnable,
  input  logic        segmentEnable,
  input  logic        closeSeg,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqPriv,
  input  logic        hit,
  output ctrlStrobe_t strobe
);

  logic guardOn;
  logic readQ, maskQ;

  assign guardOn = globalEnable && segmentEnable && hit && (!reqPriv || closeSeg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readQ <= 1'b0;
      maskQ <= 1'b0;
    end else begin
      readQ <= reqValid && !reqWrite;
      maskQ <= reqValid && !reqWrite && guardOn;
    end
  end

  always_comb begin
    strobe.fwd       = reqValid && !guardOn;
    strobe.dropWrite = reqValid && reqWrite && guardOn;
    strobe.readDue   = readQ;
    strobe.maskDue   = maskQ;
  end

  a_r7_priv_open_fwd: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqPriv && !closeSeg |-> strobe.fwd);

  a_r6_disabled_fwd: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !(globalEnable && segmentEnable) |-> strobe.fwd);

endmodule

// File: rtl/topmem_datapath.sv
module topmem_datapath
  import topmem_shield_pkg::*;
#(
  parameter int RAM_MB  = 128,
  parameter int MB_LOG2 = 20,
  parameter int IDX_W   = $clog2(RAM_MB),
  parameter int ADDR_W  = IDX_W + MB_LOG2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              segActive,
  input  logic [IDX_W-1:0]  startMb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [7:0]        reqWdata,
  output logic              hit,
  output logic              ramValid,
  output logic              ramWrite,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramWdata,
  input  logic [7:0]        ramRdata,
  output logic              rspValid,
  output logic [7:0]        rspRdata
);

  logic [IDX_W-1:0] mbIndex;
  logic             inRam;

  assign mbIndex = reqAddr[ADDR_W-1:MB_LOG2];

  generate
    if ((1 << IDX_W) == RAM_MB) begin : g_pow2
      assign inRam = 1'b1;
    end else begin : g_partial
      assign inRam = (mbIndex < IDX_W'(RAM_MB));
    end
  endgenerate

  assign hit = segActive && inRam && (mbIndex >= startMb);

  assign ramValid = strobe.fwd;
  assign ramWrite = strobe.fwd && reqWrite;
  assign ramAddr  = reqAddr;
  assign ramWdata = reqWdata;

  assign rspValid = strobe.readDue;
  assign rspRdata = strobe.maskDue ? BLOCK_FILL : ramRdata;

  a_r5_ram_idle_on_drop: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dropWrite |-> !ramValid && !ramWrite);

endmodule

// File: rtl/topmem_shield.sv
module topmem_shield
  import topmem_shield_pkg::*;
#(
  parameter int RAM_MB  = 128,
  parameter int MB_LOG2 = 20,
  parameter int EXT_W   = 12,
  parameter int ADDR_W  = $clog2(RAM_MB) + MB_LOG2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              globalEnable,
  input  logic              segmentEnable,
  input  logic              closeSeg,
  input  logic [2:0]        sizeCode,
  input  logic [EXT_W-1:0]  extSizeMb,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqPriv,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqWdata,
  output logic              rspValid,
  output logic [7:0]        rspRdata,
  output logic              ramValid,
  output logic              ramWrite,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramWdata,
  input  logic [7:0]        ramRdata
);

  localparam int IDX_W = $clog2(RAM_MB);

  ctrlStrobe_t      strobe;
  logic             segActive;
  logic [IDX_W-1:0] startMb;
  logic             hit;

  topmem_size_decode #(.RAM_MB(RAM_MB), .EXT_W(EXT_W), .IDX_W(IDX_W)) u_size (
    .sizeCode (sizeCode),
    .extSizeMb(extSizeMb),
    .segActive(segActive),
    .startMb  (startMb)
  );

  topmem_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .globalEnable (globalEnable),
    .segmentEnable(segmentEnable),
    .closeSeg     (closeSeg),
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .reqPriv      (reqPriv),
    .hit          (hit),
    .strobe       (strobe)
  );

  topmem_datapath #(.RAM_MB(RAM_MB), .MB_LOG2(MB_LOG2), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .segActive(segActive),
    .startMb  (startMb),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .reqWdata (reqWdata),
    .hit      (hit),
    .ramValid (ramValid),
    .ramWrite (ramWrite),
    .ramAddr  (ramAddr),
    .ramWdata (ramWdata),
    .ramRdata (ramRdata),
    .rspValid (rspValid),
    .rspRdata (rspRdata)
  );

  a_r9_read_answers: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite |=> rspValid);

  a_r9_no_stray_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite) |=> !rspValid);

  a_r2_ext_zero_off: assert property (@(posedge clk) disable iff (!rstN)
    sizeCode == SZ_EXT && extSizeMb == '0 |-> !segActive);

  a_r4_fill_on_block: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite && !reqPriv && globalEnable && segmentEnable && hit
      |=> rspRdata == BLOCK_FILL);

endmodule

// File: tb/test_topmem_shield.sv
module test_topmem_shield;

  localparam int RAM_MB  = 16;
  localparam int MB_LOG2 = 4;
  localparam int EXT_W   = 6;
  localparam int ADDR_W  = 8;
  localparam int NBYTES  = 256;

  logic clk = 1'b0;
  logic rstN;
  logic globalEnable, segmentEnable, closeSeg;
  logic [2:0] sizeCode;
  logic [EXT_W-1:0] extSizeMb;
  logic reqValid, reqWrite, reqPriv;
  logic [ADDR_W-1:0] reqAddr;
  logic [7:0] reqWdata;
  logic rspValid;
  logic [7:0] rspRdata;
  logic ramValid, ramWrite;
  logic [ADDR_W-1:0] ramAddr;
  logic [7:0] ramWdata;
  logic [7:0] ramRdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] mem    [NBYTES];
  logic [7:0] shadow [NBYTES];

  always #5 clk = ~clk;

  topmem_shield #(.RAM_MB(RAM_MB), .MB_LOG2(MB_LOG2), .EXT_W(EXT_W)) i_topmem_shield (
    .clk(clk), .rstN(rstN),
    .globalEnable(globalEnable), .segmentEnable(segmentEnable), .closeSeg(closeSeg),
    .sizeCode(sizeCode), .extSizeMb(extSizeMb),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqPriv(reqPriv),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata),
    .ramValid(ramValid), .ramWrite(ramWrite), .ramAddr(ramAddr),
    .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  always @(posedge clk) begin
    if (ramValid) begin
      if (ramWrite) mem[ramAddr] <= ramWdata;
      else          ramRdata <= mem[ramAddr];
    end
  end

  function automatic int sizeOf(logic [2:0] code, int ext);
    case (code)
      3'b000:  return 1;
      3'b001:  return 2;
      3'b010:  return 8;
      3'b111:  return ext;
      default: return 0;
    endcase
  endfunction

  function automatic int startOf(int sz);
    return (sz >= RAM_MB) ? 0 : RAM_MB - sz;
  endfunction

  function automatic bit inWindow(int a);
    int sz = sizeOf(sizeCode, int'(extSizeMb));
    return (sz != 0) && ((a >> MB_LOG2) >= startOf(sz));
  endfunction

  function automatic bit blockedAt(int a);
    return globalEnable && segmentEnable && inWindow(a) && (!reqPriv || closeSeg);
  endfunction

  function automatic string tagFor(int a, bit w);
    int sz = sizeOf(sizeCode, int'(extSizeMb));
    if (blockedAt(a)) return w ? "R5" : "R4";
    if (!(globalEnable && segmentEnable)) return "R6";
    if (inWindow(a) && reqPriv && !closeSeg) return "R7";
    if (sizeCode inside {3'b011, 3'b100, 3'b101, 3'b110}) return "R3";
    if (sz != 0 && (a >> MB_LOG2) == startOf(sz) - 1) return "R8";
    if (sizeCode == 3'b111) return "R2";
    return "R1";
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s addr=%0d actual=%0h expected=%0h", tag, what, reqAddr, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic access(bit w, int a, logic [7:0] d);
    bit blk;
    string tag;
    reqValid = 1'b1;
    reqWrite = w;
    reqAddr  = ADDR_W'(a);
    reqWdata = d;
    #1;
    blk = blockedAt(a);
    tag = tagFor(a, w);
    check(ramValid == !blk, blk ? tag : "R9", "ramValid", int'(ramValid), int'(!blk));
    if (!blk) begin
      check(ramAddr == ADDR_W'(a) && ramWrite == w, "R9", "ram addr/write",
            int'({ramWrite, ramAddr}), int'({w, ADDR_W'(a)}));
      if (w) check(ramWdata == d, "R9", "ramWdata", int'(ramWdata), int'(d));
    end
    @(negedge clk);
    if (w) begin
      check(rspValid == 1'b0, "R9", "rspValid after write", int'(rspValid), 0);
      if (!blk) shadow[a] = d;
    end else begin
      check(rspValid == 1'b1, "R9", "rspValid after read", int'(rspValid), 1);
      check(rspRdata == (blk ? 8'hFF : shadow[a]), tag, "rspRdata",
            int'(rspRdata), int'(blk ? 8'hFF : shadow[a]));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [2:0] codes [8] = '{3'b000, 3'b001, 3'b010, 3'b111, 3'b111, 3'b111, 3'b111, 3'b011};
    int         exts  [8] = '{0, 0, 0, 0, 5, 16, 40, 9};
    for (int i = 0; i < NBYTES; i++) begin
      mem[i]    = 8'h00;
      shadow[i] = 8'h00;
    end
    rstN = 1'b0;
    globalEnable = 1'b0; segmentEnable = 1'b0; closeSeg = 1'b0;
    sizeCode = 3'b000; extSizeMb = '0;
    reqValid = 1'b0; reqWrite = 1'b0; reqPriv = 1'b0;
    reqAddr = '0; reqWdata = '0;
    repeat (3) @(negedge clk);
    check(rspValid == 1'b0, "R10", "rspValid in reset", int'(rspValid), 0);
    check(ramValid == 1'b0, "R10", "ramValid idle", int'(ramValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rspValid == 1'b0, "R10", "rspValid after reset", int'(rspValid), 0);

    for (int cfg = 0; cfg < 8; cfg++) begin
      sizeCode  = codes[cfg];
      extSizeMb = EXT_W'(exts[cfg]);
      for (int mode = 0; mode < 16; mode++) begin
        globalEnable  = mode[3];
        segmentEnable = mode[2];
        reqPriv       = mode[1];
        closeSeg      = mode[0];
        for (int a = 0; a < NBYTES; a++)
          access(1'b1, a, 8'(a ^ (cfg * 16 + mode) * 37));
        for (int a = 0; a < NBYTES; a++)
          access(1'b0, a, 8'h00);
      end
    end

    reqValid = 1'b0;
    @(negedge clk);
    check(rspValid == 1'b0, "R9", "idle after sweep", int'(rspValid), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule